// File: doc/BRIEF.md
# Boundary-Pausing Single-Address DMA Engine

This block moves data for a card host controller between a byte-wide stream port and a simple memory request port, using one linear system address. Software loads the start address, the block size, the block count, a boundary select and a transfer mode through a small register write port. The block then streams bytes one at a time, advancing the address after every byte. In the read direction the stream feeds memory writes. In the write direction the block issues memory reads and hands the returned bytes to the outgoing stream.

The engine stops each time the next address lands on a multiple of the selected power-of-two boundary. It then raises a boundary status bit and stays paused until software writes the address register again. A transfer-complete status bit is raised after the final byte of the final block. Both status bits are cleared by writing a one to them. The system address output always shows the next address the engine will touch.

Stream and memory handshakes are valid/ready. A beat happens only on a cycle where both sides are high. The engine keeps its memory request valid, with a stable address, until ready is seen. An offered output byte stays valid and unchanged until the consumer takes it. An upstream byte is accepted only in a cycle where memory accepts the matching write.

Top module: `sdma_engine`

## Requirements
- R1: After reset the engine is idle: `sys_addr` is 0, `dma_irq` and `done_irq` are low, and no request or stream handshake is active.
- R2: A transfer starts only on a write to the mode register (offset 3) with bit 0 set, while the engine is idle. The host-control register (offset 4) bits [4:3] must equal 00. The block size must be non-zero. When mode bits 5 and 1 are both set, the block count must also be non-zero. Any other case leaves the engine idle.
- R3: With mode bit 4 set (read), each byte taken from `in_data` becomes a memory write of that byte at `sys_addr`. `in_ready` follows `mem_ready`, and `mem_valid` follows `in_valid`.
- R4: With mode bit 4 clear (write), the engine issues one memory read at a time. It holds `mem_valid` and `mem_addr` until `mem_ready`. It captures `rsp_data` on `rsp_valid` and holds it on `out_data` with `out_valid` until `out_ready`.
- R5: Block size is bits [11:0] of offset 1, and the 16-bit block count is at offset 2. With mode bit 5 set and bit 1 set, exactly that many blocks move. With bit 5 clear, exactly one block moves. With bit 5 set and bit 1 clear, blocks are not counted and the transfer never completes.
- R6: The boundary is 2^(BOUND_LG_BASE + s) bytes, where s is bits [14:12] of offset 1. After a byte that does not finish the transfer, if the next address is a multiple of the boundary, the engine pauses and status bit 3 (`dma_irq`) sets.
- R7: Writing a one to bit 3 or bit 1 of the status register (offset 5) clears that bit. Clearing bit 3 does not resume a paused transfer.
- R8: A write to the address register (offset 0) while paused resumes the transfer from the written address. Such a write while running is ignored. While idle, it loads the address.
- R9: After the last byte of the last block, status bit 1 (`done_irq`) sets and the engine goes idle. A transfer that ends exactly on a boundary does not raise `dma_irq`.
- R10: `sys_addr` advances by one on every byte beat and shows the next address to be accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| sys_addr | output | AW | Next address to access |
| dma_irq | output | 1 | Boundary pause status |
| done_irq | output | 1 | Transfer complete status |
| in_valid | input | 1 | Upstream byte valid (read direction) |
| in_ready | output | 1 | Upstream byte accepted |
| in_data | input | DW | Upstream byte |
| out_valid | output | 1 | Downstream byte valid (write direction) |
| out_ready | input | 1 | Downstream consumer ready |
| out_data | output | DW | Downstream byte |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Memory write byte |
| rsp_valid | input | 1 | Memory read response valid |
| rsp_data | input | DW | Memory read response byte |

## Verification
The bench builds the engine with `BOUND_LG_BASE` set to 3. The boundary select then spans 8 to 1024 bytes instead of 4 KiB to 512 KiB. This makes pauses, resumes to a new address, and a transfer that completes exactly on a boundary reachable within a few dozen bytes. The address width and byte width keep their defaults.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam logic [2:0] OFS_ADDR  = 3'd0;
  localparam logic [2:0] OFS_BSIZE = 3'd1;
  localparam logic [2:0] OFS_BCNT  = 3'd2;
  localparam logic [2:0] OFS_MODE  = 3'd3;
  localparam logic [2:0] OFS_HCTL  = 3'd4;
  localparam logic [2:0] OFS_STS   = 3'd5;

  localparam int MODE_EN    = 0;
  localparam int MODE_CNTEN = 1;
  localparam int MODE_RD    = 4;
  localparam int MODE_MULTI = 5;

  localparam int STS_DONE = 1;
  localparam int STS_BND  = 3;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_RUN   = 2'd1,
    ENG_PAUSE = 2'd2
  } eng_state_e;

  typedef enum logic [1:0] {
    MV_ISSUE = 2'd0,
    MV_WAIT  = 2'd1,
    MV_HOLD  = 2'd2
  } mv_state_e;

  typedef struct packed {
    logic [11:0] size;
    logic [2:0]  bsel;
    logic [15:0] count;
    logic        rd;
    logic        multi;
    logic        cnt_en;
    logic [1:0]  dsel;
  } cfg_t;

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        engine_idle,
  input  logic        set_dma,
  input  logic        set_done,
  output cfg_t        cfg,
  output logic        start_req,
  output logic [15:0] start_blocks,
  output logic        start_unbounded,
  output logic        addr_wr,
  output logic        dma_sts,
  output logic        done_sts
);

  logic wr_mode, wr_sts;
  logic new_multi, new_cnten, count_ok;

  assign wr_mode   = cfg_we && (cfg_addr == OFS_MODE);
  assign wr_sts    = cfg_we && (cfg_addr == OFS_STS);
  assign addr_wr   = cfg_we && (cfg_addr == OFS_ADDR);
  assign new_multi = cfg_wdata[MODE_MULTI];
  assign new_cnten = cfg_wdata[MODE_CNTEN];
  assign count_ok  = !(new_multi && new_cnten) || (cfg.count != 16'd0);

  assign start_req = wr_mode && cfg_wdata[MODE_EN] && engine_idle &&
                     (cfg.dsel == 2'b00) && (cfg.size != 12'd0) && count_ok;
  assign start_blocks    = new_multi ? cfg.count : 16'd1;
  assign start_unbounded = new_multi && !new_cnten;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFS_BSIZE: begin
          cfg.size <= cfg_wdata[11:0];
          cfg.bsel <= cfg_wdata[14:12];
        end
        OFS_BCNT: cfg.count <= cfg_wdata[15:0];
        OFS_MODE: begin
          cfg.rd     <= cfg_wdata[MODE_RD];
          cfg.multi  <= cfg_wdata[MODE_MULTI];
          cfg.cnt_en <= cfg_wdata[MODE_CNTEN];
        end
        OFS_HCTL: cfg.dsel <= cfg_wdata[4:3];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_sts  <= 1'b0;
      done_sts <= 1'b0;
    end else begin
      dma_sts  <= set_dma  | (dma_sts  & ~(wr_sts & cfg_wdata[STS_BND]));
      done_sts <= set_done | (done_sts & ~(wr_sts & cfg_wdata[STS_DONE]));
    end
  end

  p_bnd_status_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_dma |=> dma_sts);

  p_done_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> done_sts);

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int AW            = 32,
  parameter int BOUND_LG_BASE = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [11:0]   start_size,
  input  logic [15:0]   start_blocks,
  input  logic          start_unbounded,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic [2:0]    bsel,
  input  logic          beat,
  output logic          run,
  output logic          idle,
  output logic [AW-1:0] addr_q,
  output logic          set_dma,
  output logic          set_done
);

  eng_state_e    st;
  logic [11:0]   size_q;
  logic [11:0]   byte_left;
  logic [15:0]   blk_left;
  logic          unbounded;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] bmask;
  logic          hit_bound;
  logic          last_byte;
  logic          last_all;

  assign run  = (st == ENG_RUN);
  assign idle = (st == ENG_IDLE);

  assign next_addr = addr_q + AW'(1);
  assign bmask     = (AW'(1) << (BOUND_LG_BASE + int'(bsel))) - AW'(1);
  assign hit_bound = ((next_addr & bmask) == '0);
  assign last_byte = (byte_left == 12'd1);
  assign last_all  = last_byte && !unbounded && (blk_left == 16'd1);

  assign set_done = run && beat && last_all;
  assign set_dma  = run && beat && !last_all && hit_bound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ENG_IDLE;
      addr_q    <= '0;
      size_q    <= '0;
      byte_left <= '0;
      blk_left  <= '0;
      unbounded <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (addr_wr) addr_q <= addr_wdata;
          if (start_req) begin
            st        <= ENG_RUN;
            size_q    <= start_size;
            byte_left <= start_size;
            blk_left  <= start_blocks;
            unbounded <= start_unbounded;
          end
        end
        ENG_RUN: begin
          if (beat) begin
            addr_q <= next_addr;
            if (last_all) begin
              st <= ENG_IDLE;
            end else begin
              if (last_byte) begin
                byte_left <= size_q;
                if (!unbounded) blk_left <= blk_left - 16'd1;
              end else begin
                byte_left <= byte_left - 12'd1;
              end
              if (hit_bound) st <= ENG_PAUSE;
            end
          end
        end
        ENG_PAUSE: begin
          if (addr_wr) begin
            addr_q <= addr_wdata;
            st     <= ENG_RUN;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  p_pause_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_PAUSE) && !addr_wr |=> $stable(addr_q));

  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && beat |=> addr_q == $past(addr_q) + AW'(1));

  p_run_addr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run && !beat |=> $stable(addr_q));

endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
  import sdma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rd,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          beat
);

  mv_state_e     mst;
  logic [DW-1:0] hold_q;

  assign mem_we    = rd;
  assign mem_wdata = in_data;
  assign in_ready  = run && rd && mem_ready;
  assign mem_valid = run && (rd ? in_valid : (mst == MV_ISSUE));
  assign out_valid = run && !rd && (mst == MV_HOLD);
  assign out_data  = hold_q;
  assign beat      = run && (rd ? (in_valid && mem_ready)
                                : ((mst == MV_HOLD) && out_ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst    <= MV_ISSUE;
      hold_q <= '0;
    end else if (run && !rd) begin
      case (mst)
        MV_ISSUE: if (mem_ready) mst <= MV_WAIT;
        MV_WAIT: begin
          if (rsp_valid) begin
            hold_q <= rsp_data;
            mst    <= MV_HOLD;
          end
        end
        MV_HOLD: if (out_ready) mst <= MV_ISSUE;
        default: mst <= MV_ISSUE;
      endcase
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we && !mem_ready |=> mem_valid);

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !in_ready && !out_valid && !mem_valid);

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int AW            = 32,
  parameter int DW            = 8,
  parameter int BOUND_LG_BASE = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [AW-1:0] sys_addr,
  output logic          dma_irq,
  output logic          done_irq,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data
);

  cfg_t          cfg;
  logic          start_req, start_unbounded, addr_wr;
  logic [15:0]   start_blocks;
  logic          run, idle, set_dma, set_done, beat;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_wdata;

  assign addr_wdata = AW'(cfg_wdata);

  sdma_regs u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_we          (cfg_we),
    .cfg_addr        (cfg_addr),
    .cfg_wdata       (cfg_wdata),
    .engine_idle     (idle),
    .set_dma         (set_dma),
    .set_done        (set_done),
    .cfg             (cfg),
    .start_req       (start_req),
    .start_blocks    (start_blocks),
    .start_unbounded (start_unbounded),
    .addr_wr         (addr_wr),
    .dma_sts         (dma_irq),
    .done_sts        (done_irq)
  );

  sdma_ctrl #(
    .AW            (AW),
    .BOUND_LG_BASE (BOUND_LG_BASE)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_req       (start_req),
    .start_size      (cfg.size),
    .start_blocks    (start_blocks),
    .start_unbounded (start_unbounded),
    .addr_wr         (addr_wr),
    .addr_wdata      (addr_wdata),
    .bsel            (cfg.bsel),
    .beat            (beat),
    .run             (run),
    .idle            (idle),
    .addr_q          (addr_q),
    .set_dma         (set_dma),
    .set_done        (set_done)
  );

  sdma_mover #(
    .DW (DW)
  ) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .rd        (cfg.rd),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .beat      (beat)
  );

  assign sys_addr = addr_q;
  assign mem_addr = addr_q;

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> !mem_valid && !in_ready && !out_valid);

endmodule

// File: tb/test_sdma_engine.sv
module test_sdma_engine;

  localparam int AW = 32;
  localparam int DW = 8;
  localparam int LGB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [AW-1:0] sys_addr;
  logic          dma_irq, done_irq;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;

  always #2 clk = ~clk;

  sdma_engine #(.AW(AW), .DW(DW), .BOUND_LG_BASE(LGB)) i_sdma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sys_addr(sys_addr), .dma_irq(dma_irq),
    .done_irq(done_irq), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int errs   = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // ---------------- reference model ----------------
  int          m_st;     // 0 idle, 1 run, 2 pause
  logic [31:0] m_addr;
  int          m_size, m_bl, m_kl;
  bit          m_inf, m_dma, m_done;
  int          m_ws;     // 0 issue, 1 wait, 2 hold
  logic [7:0]  m_hold;
  int          r_sz, r_sel, r_cnt, r_hctl;
  bit          r_rd;
  bit          rsp_pend = 0;
  logic [7:0]  rsp_dat = '0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic model_reset();
    m_st = 0; m_addr = 0; m_size = 0; m_bl = 0; m_kl = 0; m_inf = 0;
    m_dma = 0; m_done = 0; m_ws = 0; m_hold = 0;
    r_sz = 0; r_sel = 0; r_cnt = 0; r_hctl = 0; r_rd = 0;
  endtask

  initial model_reset();

  always @(negedge clk) begin
    bit run, ev_mv, ev_ir, ev_ov, beat, nd, nm;
    logic [31:0] mask, nxt;
    if (!rst_n) model_reset();
    run   = (m_st == 1);
    ev_mv = run && (r_rd ? in_valid : (m_ws == 0));
    ev_ir = run && r_rd && mem_ready;
    ev_ov = run && !r_rd && (m_ws == 2);
    chk(sys_addr == m_addr, "R10 sys_addr", sys_addr, m_addr);
    chk(dma_irq == m_dma, "R6 dma_irq", dma_irq, m_dma);
    chk(done_irq == m_done, "R9 done_irq", done_irq, m_done);
    chk(mem_valid == ev_mv, "R3 mem_valid", mem_valid, ev_mv);
    chk(in_ready == ev_ir, "R3 in_ready", in_ready, ev_ir);
    chk(out_valid == ev_ov, "R4 out_valid", out_valid, ev_ov);
    if (ev_mv) begin
      chk(mem_addr == m_addr, "R3 mem_addr", mem_addr, m_addr);
      chk(mem_we == r_rd, "R3 mem_we", mem_we, r_rd);
      if (r_rd) chk(mem_wdata == in_data, "R3 mem_wdata", mem_wdata, in_data);
    end
    if (ev_ov) chk(out_data == m_hold, "R4 out_data", out_data, m_hold);
    if (rst_n) begin
      if (mem_valid && !mem_we && mem_ready) begin
        rsp_pend = 1; rsp_dat = pat(mem_addr);
      end
      beat = run && (r_rd ? (in_valid && mem_ready) : (m_ws == 2 && out_ready));
      nd = 0; nm = 0;
      if (run && !r_rd) begin
        if (m_ws == 0 && mem_ready) m_ws = 1;
        else if (m_ws == 1 && rsp_valid) begin m_ws = 2; m_hold = rsp_data; end
        else if (m_ws == 2 && out_ready) m_ws = 0;
      end
      if (beat) begin
        nxt  = m_addr + 1;
        mask = (32'd1 << (LGB + r_sel)) - 1;
        m_addr = nxt;
        if (m_bl == 1 && !m_inf && m_kl == 1) begin
          m_st = 0; nd = 1;
        end else begin
          if (m_bl == 1) begin
            m_bl = m_size;
            if (!m_inf) m_kl--;
          end else m_bl--;
          if ((nxt & mask) == 0) begin m_st = 2; nm = 1; end
        end
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: if (m_st != 1) begin
                  m_addr = cfg_wdata;
                  if (m_st == 2) m_st = 1;
                end
          3'd1: begin r_sz = cfg_wdata[11:0]; r_sel = cfg_wdata[14:12]; end
          3'd2: r_cnt = cfg_wdata[15:0];
          3'd3: begin
            if (m_st == 0 && cfg_wdata[0] && r_hctl[4:3] == 0 && r_sz != 0 &&
                !(cfg_wdata[5] && cfg_wdata[1] && r_cnt == 0)) begin
              m_st = 1; m_size = r_sz; m_bl = r_sz;
              m_kl = cfg_wdata[5] ? r_cnt : 1;
              m_inf = cfg_wdata[5] && !cfg_wdata[1];
            end
            r_rd = cfg_wdata[4];
          end
          3'd4: r_hctl = cfg_wdata[7:0];
          3'd5: begin
            if (cfg_wdata[3]) m_dma = 0;
            if (cfg_wdata[1]) m_done = 0;
          end
          default: ;
        endcase
      end
      if (nm) m_dma = 1;
      if (nd) m_done = 1;
    end
  end

  // ---------------- stimulus drivers ----------------
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      in_valid  = (cyc % 3) != 0;
      in_data   = 8'(cyc * 7);
      mem_ready = (cyc % 4) != 1;
      out_ready = (cyc % 5) != 2;
      rsp_valid = rsp_pend;
      rsp_data  = rsp_dat;
      rsp_pend  = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finish");
    summary();
  end

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic setup(input logic [31:0] a, input int sz, input int sel,
                       input int cnt);
    cfg_write(3'd0, a);
    cfg_write(3'd1, 32'((sel << 12) | sz));
    cfg_write(3'd2, 32'(cnt));
  endtask

  task automatic wait_evt();
    @(negedge clk);
    while (!(dma_irq || done_irq)) @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sys_addr == 0, "R1 reset sys_addr", sys_addr, 0);
    chk(!dma_irq && !done_irq, "R1 reset status", {dma_irq, done_irq}, 0);
    chk(!mem_valid && !in_ready && !out_valid, "R1 reset quiet", mem_valid, 0);

    // R2 non-SDMA select leaves it idle
    cfg_write(3'd4, 32'h10);
    setup(32'h300, 4, 0, 2);
    cfg_write(3'd3, 32'h33);
    repeat (10) @(negedge clk);
    chk(!mem_valid && sys_addr == 32'h300, "R2 select code idle", mem_valid, 0);
    // R2 zero block count with counting and multi
    cfg_write(3'd4, 32'h0);
    cfg_write(3'd2, 32'h0);
    cfg_write(3'd3, 32'h33);
    repeat (10) @(negedge clk);
    chk(!mem_valid && !done_irq, "R2 zero count idle", mem_valid, 0);

    // R5 single block ignores count; R3 read direction
    setup(32'h100, 5, 7, 9);
    cfg_write(3'd3, 32'h13);
    wait_evt();
    chk(done_irq, "R9 single done", done_irq, 1);
    chk(sys_addr == 32'h105, "R5 single block one", sys_addr, 32'h105);
    chk(!dma_irq, "R9 no boundary", dma_irq, 0);
    cfg_write(3'd5, 32'h2);
    @(negedge clk);
    chk(!done_irq, "R7 done cleared", done_irq, 0);

    // R6 R7 R8 multi-block read with pauses
    setup(32'h40, 6, 0, 3);
    cfg_write(3'd3, 32'h33);
    cfg_write(3'd0, 32'h999);   // ignored while running (R8)
    wait_evt();
    chk(dma_irq && sys_addr == 32'h48, "R6 pause at boundary", sys_addr, 32'h48);
    cfg_write(3'd5, 32'h8);
    @(negedge clk);
    chk(!dma_irq, "R7 boundary cleared", dma_irq, 0);
    repeat (6) @(negedge clk);
    chk(!mem_valid && sys_addr == 32'h48, "R7 clear does not resume", mem_valid, 0);
    cfg_write(3'd0, 32'h200);
    wait_evt();
    chk(dma_irq && sys_addr == 32'h208, "R8 resume from written", sys_addr, 32'h208);
    cfg_write(3'd5, 32'h8);
    cfg_write(3'd0, 32'h208);
    wait_evt();
    chk(done_irq && sys_addr == 32'h20A, "R9 multi done count", sys_addr, 32'h20A);
    cfg_write(3'd5, 32'hA);

    // R4 write direction
    setup(32'h0C, 8, 1, 2);
    cfg_write(3'd3, 32'h23);
    wait_evt();
    chk(dma_irq && sys_addr == 32'h10, "R4 write dir pause", sys_addr, 32'h10);
    cfg_write(3'd5, 32'h8);
    cfg_write(3'd0, 32'h10);
    wait_evt();
    chk(done_irq && sys_addr == 32'h1C, "R4 write dir done", sys_addr, 32'h1C);
    cfg_write(3'd5, 32'hA);

    // R9 completion exactly on a boundary
    setup(32'h38, 8, 1, 1);
    cfg_write(3'd3, 32'h13);
    wait_evt();
    repeat (2) @(negedge clk);
    chk(done_irq && !dma_irq && sys_addr == 32'h40, "R9 ends on boundary",
        {dma_irq, done_irq}, 1);
    cfg_write(3'd5, 32'hA);

    // R5 multi-block without counting never completes
    setup(32'h0, 2, 0, 1);
    cfg_write(3'd3, 32'h31);
    wait_evt();
    chk(dma_irq && !done_irq && sys_addr == 8, "R5 uncounted pass 1", sys_addr, 8);
    cfg_write(3'd5, 32'h8);
    cfg_write(3'd0, 32'h8);
    wait_evt();
    chk(dma_irq && !done_irq && sys_addr == 32'h10, "R5 uncounted pass 2",
        sys_addr, 32'h10);

    do_reset();
    @(negedge clk);
    chk(sys_addr == 0 && !dma_irq && !done_irq && !mem_valid, "R1 after reset",
        sys_addr, 0);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule